// File: doc/BRIEF.md
# Phase-locked cycle timer with PI reload

The block is a free-running cycle counter that produces a local cycle pulse and pulls its phase onto a remote frame strobe. The counter runs from 0 up to the current reload value minus one and then wraps. The cycle pulse is high for the one clock in which the count is 0. On every rising edge of the frame strobe, the block captures the running count. It turns that count into a signed phase error relative to the ideal strobe position, which is count 0.

The error feeds a proportional-integral controller. The gains are in units of 1/256 count per count of error. The integer part of the controller output adjusts the next reload value. The fractional part is accumulated once per cycle, and each overflow lengthens one period by a single count. This lets a remote rate of, for example, 5000.05 ticks per cycle be met by mostly 5000-tick cycles with an occasional 5001-tick cycle.

The reload value is kept within ±1 % of the nominal period. If strobes stop arriving, the controller holds its last state and the lock flag drops. All inputs and outputs are plain control and status pins: there is no data stream and no back-pressure.

Top module: `cyc_lock_timer`

## Requirements
- R1: The cycle pulse `cycle_o` is high for exactly one clock, when the count is 0. The spacing between pulses equals the reload value in use. With both gains at 0, every spacing equals `nominal_i`.
- R2: A rising edge on `frame_i` captures count c. Let P be the current period. The error is e = c if c ≤ floor(P/2), and e = c − P otherwise. `phase_err_o` shows e from the clock after the edge and holds it until the next edge.
- R3: Let u = kp·e_last + I, where I is the integrator and u is in 1/256 counts. Each wrap loads the next period as nominal + floor(u/256) + dither carry. A strobe that arrives in the wrap clock itself affects only the period after next.
- R4: Each strobe adds ki·e to the integrator I, in 1/256 counts. The integrator changes at no other time.
- R5: The low 8 bits of u are added once per wrap to an 8-bit fraction register. A carry out of that register adds one count to the next period, so periods take only floor and floor+1 values.
- R6: Every reload value stays within nominal ± floor(nominal/100).
- R7: The integrator saturates at ±floor(nominal/100)·256, so a later error of opposite sign acts from that limit.
- R8: `lock_o` rises on the 8th consecutive strobe with |e| ≤ 2. Any strobe with |e| > 2 clears it.
- R9: If no strobe arrives for P + floor(nominal/100) clocks, `lock_o` drops. The controller state is held, and the cycle pulses continue with the same periods.
- R10: Synchronous active-low reset clears the count, the lock, the error, the integrator and the fraction, and loads the period with `nominal_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, one count per edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_i | input | 1 | Remote frame strobe; rising edge is the timing event |
| nominal_i | input | 16 | Nominal period in counts (at least 2, stable outside reset) |
| kp_i | input | 10 | Proportional gain, 1/256 units |
| ki_i | input | 10 | Integral gain, 1/256 units |
| cycle_o | output | 1 | One-clock local cycle pulse |
| phase_err_o | output | 17 | Signed phase error of the last strobe |
| lock_o | output | 1 | Phase lock indication |

## Verification
The critical overlap is a strobe edge landing in the wrap clock. In that clock the capture logic and the reload computation act on the same edge. The bench drives the strobe at count P−1 with a purely proportional gain. It expects an error of −1, an unchanged following period and a shortened period after that, which proves that the reload used the controller state from before the strobe. Phase capture is swept over every offset for an even and an odd period. Dither, clamp and saturation are judged against period sequences worked out arithmetically from the gains.

// File: rtl/cyc_lock_pkg.sv
package cyc_lock_pkg;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_FRAC_W = 8;
  localparam int DEF_GAIN_W = 10;

  typedef enum logic {
    LK_SEEK = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;
endpackage

// File: rtl/phase_capture.sv
module phase_capture #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        margin_i,
  output logic                    edge_o,
  output logic signed [CNT_W:0]   err_c_o,
  output logic signed [CNT_W:0]   err_q_o,
  output logic                    stale_o
);
  localparam int GAP_W = CNT_W + 2;

  logic             frame_q;
  logic [CNT_W-1:0] half;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] win;
  logic [CNT_W:0]   err_mag;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_i;
  end

  assign edge_o = frame_i & ~frame_q;
  assign half   = period_i >> 1;

  // late strobe is positive, early strobe wraps to negative
  always_comb begin
    if (count_i <= half)
      err_c_o = $signed({1'b0, count_i});
    else
      err_c_o = $signed({1'b0, count_i}) - $signed({1'b0, period_i});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q_o <= '0;
    else if (edge_o) err_q_o <= err_c_o;
  end

  // strobe silence window: one period plus the clamp margin
  assign win = {2'b00, period_i} + {2'b00, margin_i};

  always_ff @(posedge clk) begin
    if (!rst_n)           gap_q <= '0;
    else if (edge_o)      gap_q <= '0;
    else if (gap_q < win) gap_q <= gap_q + 1'b1;
  end

  assign stale_o = (gap_q >= win);
  assign err_mag = err_q_o[CNT_W] ? $unsigned(-err_q_o) : $unsigned(err_q_o);

  // R2
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_o |=> $stable(err_q_o));

  // R2
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (err_mag <= {1'b0, $past(half)}));
endmodule

// File: rtl/pi_ctrl.sv
module pi_ctrl #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int GAIN_W = 10,
  parameter int U_W    = CNT_W + FRAC_W + GAIN_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  edge_i,
  input  logic signed [CNT_W:0] err_i,
  input  logic [GAIN_W-1:0]     kp_i,
  input  logic [GAIN_W-1:0]     ki_i,
  input  logic [CNT_W-1:0]      margin_i,
  output logic signed [U_W-1:0] u_o
);
  logic signed [U_W-1:0] err_w, kp_w, ki_w, lim_w;
  logic signed [U_W-1:0] acc_q, p_q, acc_sum, acc_nxt;

  assign err_w = {{(U_W-CNT_W-1){err_i[CNT_W]}}, err_i};
  assign kp_w  = {{(U_W-GAIN_W){1'b0}}, kp_i};
  assign ki_w  = {{(U_W-GAIN_W){1'b0}}, ki_i};
  assign lim_w = {{(U_W-CNT_W-FRAC_W){1'b0}}, margin_i, {FRAC_W{1'b0}}};

  assign acc_sum = acc_q + ki_w * err_w;

  // anti-windup: integrator never leaves the clamp range
  always_comb begin
    if (acc_sum > lim_w)       acc_nxt = lim_w;
    else if (acc_sum < -lim_w) acc_nxt = -lim_w;
    else                       acc_nxt = acc_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      p_q   <= '0;
    end else if (edge_i) begin
      acc_q <= acc_nxt;
      p_q   <= kp_w * err_w;
    end
  end

  assign u_o = acc_q + p_q;

  // R7
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= lim_w) && (acc_q >= -lim_w));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_i |=> $stable(acc_q));
endmodule

// File: rtl/reload_gen.sv
module reload_gen #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int U_W    = 36
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      nominal_i,
  input  logic [CNT_W-1:0]      margin_i,
  input  logic signed [U_W-1:0] u_i,
  output logic [CNT_W-1:0]      count_o,
  output logic [CNT_W-1:0]      period_o,
  output logic                  cycle_o
);
  logic [CNT_W-1:0]      count_q, period_q, period_nxt;
  logic [FRAC_W-1:0]     frac_q;
  logic [FRAC_W:0]       frac_sum;
  logic                  wrap;
  logic signed [U_W-1:0] u_int, nom_w, mar_w, carry_w, raw, lo, hi;

  assign wrap     = (count_q >= period_q - 1'b1);
  assign frac_sum = {1'b0, frac_q} + {1'b0, u_i[FRAC_W-1:0]};

  assign u_int   = u_i >>> FRAC_W;
  assign nom_w   = {{(U_W-CNT_W){1'b0}}, nominal_i};
  assign mar_w   = {{(U_W-CNT_W){1'b0}}, margin_i};
  assign carry_w = {{(U_W-1){1'b0}}, frac_sum[FRAC_W]};
  assign raw     = nom_w + u_int + carry_w;
  assign lo      = nom_w - mar_w;
  assign hi      = nom_w + mar_w;

  always_comb begin
    if (raw > hi)      period_nxt = hi[CNT_W-1:0];
    else if (raw < lo) period_nxt = lo[CNT_W-1:0];
    else               period_nxt = raw[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      period_q <= nominal_i;
      frac_q   <= '0;
    end else if (wrap) begin
      count_q  <= '0;
      period_q <= period_nxt;
      frac_q   <= frac_sum[FRAC_W-1:0];
    end else begin
      count_q  <= count_q + 1'b1;
    end
  end

  assign count_o  = count_q;
  assign period_o = period_q;
  assign cycle_o  = (count_q == '0);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < period_q);

  // R1
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_o |=> !cycle_o);

  // R6
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q >= nominal_i - margin_i) && (period_q <= nominal_i + margin_i));
endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
  parameter int CNT_W   = 16,
  parameter int RUN_N   = 8,
  parameter int TOL     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  edge_i,
  input  logic signed [CNT_W:0] err_i,
  input  logic                  stale_i,
  output logic                  lock_o
);
  import cyc_lock_pkg::*;

  localparam int RUN_W = $clog2(RUN_N + 1);
  localparam logic [RUN_W-1:0]      RUN_MAX  = RUN_W'(RUN_N);
  localparam logic [RUN_W-1:0]      RUN_LAST = RUN_W'(RUN_N - 1);
  localparam logic signed [CNT_W:0] TOL_W    = (CNT_W+1)'(TOL);

  logic [RUN_W-1:0] run_q;
  lock_state_e      st_q;
  logic             in_tol;

  assign in_tol = (err_i <= TOL_W) && (err_i >= -TOL_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      st_q  <= LK_SEEK;
    end else if (edge_i) begin
      if (in_tol) begin
        run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        st_q  <= (run_q >= RUN_LAST) ? LK_HELD : LK_SEEK;
      end else begin
        run_q <= '0;
        st_q  <= LK_SEEK;
      end
    end else if (stale_i) begin
      run_q <= '0;
      st_q  <= LK_SEEK;
    end
  end

  assign lock_o = (st_q == LK_HELD);

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(edge_i));

  // R8
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !in_tol) |=> !lock_o);

  // R9
  stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_i && !edge_i) |=> !lock_o);
endmodule

// File: rtl/cyc_lock_timer.sv
module cyc_lock_timer #(
  parameter int CNT_W     = cyc_lock_pkg::DEF_CNT_W,
  parameter int FRAC_W    = cyc_lock_pkg::DEF_FRAC_W,
  parameter int GAIN_W    = cyc_lock_pkg::DEF_GAIN_W,
  parameter int CLAMP_DIV = 100,
  parameter int LOCK_RUN  = 8,
  parameter int LOCK_TOL  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_i,
  input  logic [CNT_W-1:0]    nominal_i,
  input  logic [GAIN_W-1:0]   kp_i,
  input  logic [GAIN_W-1:0]   ki_i,
  output logic                cycle_o,
  output logic signed [CNT_W:0] phase_err_o,
  output logic                lock_o
);
  localparam int U_W = CNT_W + FRAC_W + GAIN_W + 2;
  localparam logic [CNT_W-1:0] DIV = CNT_W'(CLAMP_DIV);

  logic [CNT_W-1:0]      margin, count, period;
  logic                  strobe, stale;
  logic signed [CNT_W:0] err_c;
  logic signed [U_W-1:0] u;

  assign margin = nominal_i / DIV;

  phase_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .count_i(count), .period_i(period), .margin_i(margin),
    .edge_o(strobe), .err_c_o(err_c), .err_q_o(phase_err_o), .stale_o(stale)
  );

  pi_ctrl #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .U_W(U_W)) u_pi (
    .clk(clk), .rst_n(rst_n), .edge_i(strobe), .err_i(err_c),
    .kp_i(kp_i), .ki_i(ki_i), .margin_i(margin), .u_o(u)
  );

  reload_gen #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .U_W(U_W)) u_rld (
    .clk(clk), .rst_n(rst_n), .nominal_i(nominal_i), .margin_i(margin),
    .u_i(u), .count_o(count), .period_o(period), .cycle_o(cycle_o)
  );

  lock_mon #(.CNT_W(CNT_W), .RUN_N(LOCK_RUN), .TOL(LOCK_TOL)) u_lock (
    .clk(clk), .rst_n(rst_n), .edge_i(strobe), .err_i(err_c),
    .stale_i(stale), .lock_o(lock_o)
  );
endmodule

// File: tb/tb_cyc_lock_timer.sv
`timescale 1ns/1ps
module tb_cyc_lock_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic [15:0] nominal = 16'd40;
  logic [9:0]  kp = '0;
  logic [9:0]  ki = '0;
  logic        cycle;
  logic signed [16:0] perr;
  logic        lock;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cyc_lock_timer dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame), .nominal_i(nominal),
    .kp_i(kp), .ki_i(ki), .cycle_o(cycle), .phase_err_o(perr), .lock_o(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int err_exp(input int d, input int p);
    return (d <= p / 2) ? d : d - p;
  endfunction

  task automatic do_reset(input int nom, input int p, input int i);
    @(negedge clk);
    rst_n = 1'b0; frame = 1'b0;
    nominal = 16'(nom); kp = 10'(p); ki = 10'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (!cycle) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cycle);
  endtask

  task automatic strobe_here(input int d);
    repeat (d) @(negedge clk);
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic strobe_at(input int d);
    wait_pulse();
    strobe_here(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    int seq_pos[8];
    int seq_neg[9];
    seq_pos = '{500, 500, 500, 501, 500, 500, 500, 501};
    seq_neg = '{500, 499, 500, 500, 500, 499, 500, 500, 500};

    // R10 reset state
    do_reset(40, 0, 0);
    chk("R10 lock", int'(lock), 0);
    chk("R10 err", int'(perr), 0);
    chk("R10 pulse", int'(cycle), 1);

    // R1 free-running periods at zero gain
    foreach (seq_pos[k]) begin end
    wait_pulse(); measure(n); chk("R1 period40", n, 40);
    measure(n); chk("R1 period40b", n, 40);
    do_reset(41, 0, 0);
    wait_pulse(); measure(n); chk("R1 period41", n, 41);
    do_reset(200, 0, 0);
    wait_pulse(); measure(n); chk("R1 period200", n, 200);

    // R2 capture sweep, even and odd period
    do_reset(40, 0, 0);
    for (int d = 0; d < 40; d++) begin
      strobe_at(d);
      chk("R2 err p40", int'(perr), err_exp(d, 40));
    end
    do_reset(41, 0, 0);
    for (int d = 0; d < 41; d++) begin
      strobe_at(d);
      chk("R2 err p41", int'(perr), err_exp(d, 41));
    end
    repeat (60) @(negedge clk);
    chk("R2 hold", int'(perr), err_exp(40, 41));

    // R8 lock after eight in-tolerance strobes
    do_reset(40, 0, 0);
    for (int k = 0; k < 7; k++) strobe_at(2);
    chk("R8 lock after 7", int'(lock), 0);
    strobe_at(2);
    chk("R8 lock after 8", int'(lock), 1);
    strobe_at(3);
    chk("R8 drop on |e|=3", int'(lock), 0);
    for (int k = 0; k < 8; k++) strobe_at(38);
    chk("R8 lock at e=-2", int'(lock), 1);

    // R9 timeout drops lock, period held
    do_reset(200, 256, 0);
    for (int k = 0; k < 7; k++) strobe_at(0);
    strobe_at(1);
    chk("R9 locked", int'(lock), 1);
    repeat (185) @(negedge clk);
    chk("R9 lock inside window", int'(lock), 1);
    repeat (30) @(negedge clk);
    chk("R9 lock after window", int'(lock), 0);
    wait_pulse(); measure(n); chk("R9 held period", n, 201);

    // R3 proportional step
    do_reset(500, 256, 0);
    strobe_at(3);
    wait_pulse(); measure(n); chk("R3 p period", n, 503);
    measure(n); chk("R3 p period again", n, 503);

    // R3 strobe in the wrap clock
    do_reset(500, 256, 0);
    strobe_at(499);
    chk("R3 wrap err", int'(perr), -1);
    measure(n); chk("R3 wrap next uses old", n, 500);
    measure(n); chk("R3 wrap after next", n, 499);

    // R4 integral accumulation
    do_reset(500, 0, 128);
    strobe_at(2);
    wait_pulse(); measure(n); chk("R4 first", n, 501);
    strobe_here(2);
    wait_pulse(); measure(n); chk("R4 second", n, 502);

    // R5 fractional dither, positive and negative
    do_reset(500, 64, 0);
    strobe_at(1);
    wait_pulse();
    for (int k = 0; k < 8; k++) begin
      measure(n); chk("R5 dither pos", n, seq_pos[k]);
    end
    do_reset(500, 64, 0);
    strobe_at(499);
    for (int k = 0; k < 9; k++) begin
      measure(n); chk("R5 dither neg", n, seq_neg[k]);
    end

    // R6 clamp both ways
    do_reset(500, 1023, 0);
    strobe_at(100);
    wait_pulse(); measure(n); chk("R6 clamp high", n, 505);
    do_reset(500, 1023, 0);
    strobe_at(400);
    wait_pulse(); measure(n); chk("R6 clamp low", n, 495);

    // R7 integrator saturation
    do_reset(500, 0, 256);
    for (int k = 0; k < 3; k++) strobe_at(10);
    wait_pulse();
    strobe_here(502);
    chk("R7 err", int'(perr), -3);
    wait_pulse(); measure(n); chk("R7 from limit", n, 502);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule